// File: doc/BRIEF.md
# Infrared Slow-Mode Baud Strobe Generator

This block makes the timing strobes for a slow asynchronous infrared link. A fixed prescaler divides the reference clock by 26. A programmable divider then divides the result by (N+1), where N is a 6-bit count value. Each terminal count of that divider gives a one-cycle sample strobe, at sixteen times the bit rate. Every sixteenth sample strobe also raises a bit strobe in the same cycle. With a 48 MHz reference, the bit rate is 48 MHz / 26 / (N+1) / 16. The reset count of 11 gives 9600 bit/s.

The count is written through a simple write strobe with a data word. Only the low six bits are kept. A new value is held as pending and applied when the running period ends, so no period is ever cut short. Dropping the enable stops the strobes and clears every counter. The next enable therefore starts a fresh period and a fresh sixteen-sample phase.

Top module: `irbaud_gen`

## Requirements
- R1: While reset is asserted, and after reset with the enable low, neither strobe is asserted. The count register resets to 11.
- R2: While enabled with count N, sample strobes occur exactly 26*(N+1) reference cycles apart, for N from 0 to 63.
- R3: A write keeps only bits [5:0] of the data word. Bits above bit 5 have no effect on the strobe period.
- R4: The sample strobe is high for exactly one reference cycle per period.
- R5: The bit strobe is high only in the same cycle as a sample strobe, on every sixteenth sample strobe counted from enable.
- R6: A count written while running does not change the period in progress. It applies from the next period on. A write in the same cycle as a terminal count governs the period that starts right after it.
- R7: With the enable low, no strobes occur and all counters are cleared. After re-enable, the first sample strobe comes 26*(N+1)-1 cycles after the cycle in which the enable is first seen high, and the first bit strobe comes on the sixteenth sample strobe.
- R8: A count written while disabled governs the first period after the next enable.
- R9: With the reset count of 11, the first sample strobe after enable comes 311 cycles after the enable. The first bit strobe comes 4991 cycles after it, which is a bit period of 4992 reference cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Generator enable; low clears all counters |
| wr_en | input | 1 | Write strobe for the count register |
| wr_data | input | 16 | Write data; bits [5:0] hold the count N |
| sample_tick | output | 1 | One-cycle strobe at 16x the bit rate |
| bit_tick | output | 1 | One-cycle strobe at the bit rate, coincident with a sample strobe |

## Verification
The delicate overlap is a register write that lands in the same cycle as the divider's terminal count. In that cycle the divider reloads, and the reload must take the value being written, not the older pending one. The bench provokes this by raising the write strobe in the half cycle where the sample strobe is seen high. It then requires the very next period to be 26*(new+1) cycles. A second test writes in the middle of a period and requires one full period at the old count before the new one appears.

// File: rtl/irb_pkg.sv
package irb_pkg;

    localparam int unsigned IRB_BUS_W       = 16;
    localparam int unsigned IRB_CNT_W       = 6;
    localparam int unsigned IRB_PRESCALE    = 26;
    localparam int unsigned IRB_OVERSAMPLE  = 16;
    localparam int unsigned IRB_RESET_COUNT = 11;

    // Strobes passed between the stages of the generator
    typedef struct packed {
        logic pre;    // prescaler wrap
        logic samp;   // programmable divider terminal count
        logic bitt;   // sixteenth sample
    } irb_strobes_t;

    // Reference cycles in one sample period for a count value
    function automatic int unsigned irb_sample_cycles(int unsigned pre, int unsigned n);
        return pre * (n + 1);
    endfunction

endpackage

// File: rtl/irb_prescaler.sv
module irb_prescaler #(
    parameter int unsigned DIV = 26
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic wrap
);
    localparam int unsigned PW = $clog2(DIV);
    localparam logic [PW-1:0] LAST = PW'(DIV - 1);

    logic [PW-1:0] cnt_q;

    assign wrap = run && (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt_q <= '0;
        end else if (cnt_q == LAST) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + PW'(1);
        end
    end
endmodule

// File: rtl/irb_divider.sv
module irb_divider #(
    parameter int unsigned CNT_W       = 6,
    parameter int unsigned RESET_COUNT = 11
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             step,
    input  logic             wr_en,
    input  logic [CNT_W-1:0] wr_val,
    output logic             term
);
    localparam logic [CNT_W-1:0] RST_VAL = CNT_W'(RESET_COUNT);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] active_q;   // limit of the period in progress
    logic [CNT_W-1:0] pend_q;     // last written count
    logic [CNT_W-1:0] reload;

    // A write in a reload cycle is taken straight away
    always_comb begin
        reload = wr_en ? wr_val : pend_q;
    end

    assign term = run && step && (cnt_q == active_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q    <= '0;
            active_q <= RST_VAL;
            pend_q   <= RST_VAL;
        end else begin
            if (wr_en) begin
                pend_q <= wr_val;
            end
            if (!run) begin
                cnt_q    <= '0;
                active_q <= reload;
            end else if (step) begin
                if (cnt_q == active_q) begin
                    cnt_q    <= '0;
                    active_q <= reload;
                end else begin
                    cnt_q <= cnt_q + CNT_W'(1);
                end
            end
        end
    end
endmodule

// File: rtl/irb_phase.sv
module irb_phase #(
    parameter int unsigned OVS = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic samp,
    output logic bitt
);
    localparam int unsigned PHW = $clog2(OVS);
    localparam logic [PHW-1:0] LAST = PHW'(OVS - 1);

    logic [PHW-1:0] ph_q;

    assign bitt = samp && (ph_q == LAST);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            ph_q <= '0;
        end else if (samp) begin
            ph_q <= (ph_q == LAST) ? '0 : ph_q + PHW'(1);
        end
    end
endmodule

// File: rtl/irbaud_gen.sv
module irbaud_gen
    import irb_pkg::*;
#(
    parameter int unsigned BUS_W       = IRB_BUS_W,
    parameter int unsigned CNT_W       = IRB_CNT_W,
    parameter int unsigned PRESCALE    = IRB_PRESCALE,
    parameter int unsigned OVERSAMPLE  = IRB_OVERSAMPLE,
    parameter int unsigned RESET_COUNT = IRB_RESET_COUNT
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             wr_en,
    input  logic [BUS_W-1:0] wr_data,
    output logic             sample_tick,
    output logic             bit_tick
);
    irb_strobes_t     st;
    logic [CNT_W-1:0] wr_val;

    assign wr_val = wr_data[CNT_W-1:0];

    generate
        if (BUS_W > CNT_W) begin : g_drop_upper
            logic unused_upper;
            assign unused_upper = ^wr_data[BUS_W-1:CNT_W];
        end
    endgenerate

    irb_prescaler #(.DIV(PRESCALE)) u_pre (
        .clk  (clk),
        .rst  (rst),
        .run  (en),
        .wrap (st.pre)
    );

    irb_divider #(.CNT_W(CNT_W), .RESET_COUNT(RESET_COUNT)) u_div (
        .clk    (clk),
        .rst    (rst),
        .run    (en),
        .step   (st.pre),
        .wr_en  (wr_en),
        .wr_val (wr_val),
        .term   (st.samp)
    );

    irb_phase #(.OVS(OVERSAMPLE)) u_phase (
        .clk  (clk),
        .rst  (rst),
        .run  (en),
        .samp (st.samp),
        .bitt (st.bitt)
    );

    assign sample_tick = st.samp;
    assign bit_tick    = st.bitt;
endmodule

// File: rtl/irbaud_gen_chk.sv
module irbaud_gen_chk #(
    parameter int unsigned PRESCALE = 26,
    parameter int unsigned OVS      = 16
) (
    input logic clk,
    input logic rst,
    input logic en,
    input logic sample_tick,
    input logic bit_tick
);
    int unsigned gap_q;
    int unsigned seen_q;

    always_ff @(posedge clk) begin
        if (rst || !en || sample_tick) begin
            gap_q <= 0;
        end else if (gap_q != 32'hFFFF_FFFF) begin
            gap_q <= gap_q + 1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            seen_q <= 0;
        end else if (sample_tick) begin
            seen_q <= (seen_q == OVS - 1) ? 0 : seen_q + 1;
        end
    end

    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        sample_tick |=> !sample_tick); // R4
    AST_BIT_ALIGNED: assert property (@(posedge clk) disable iff (rst)
        bit_tick |-> sample_tick); // R5
    AST_BIT_SIXTEENTH: assert property (@(posedge clk) disable iff (rst)
        bit_tick |-> (seen_q == OVS - 1)); // R5
    AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (rst)
        !en |-> (!sample_tick && !bit_tick)); // R7
    AST_MIN_GAP: assert property (@(posedge clk) disable iff (rst)
        sample_tick |-> (gap_q >= PRESCALE - 1)); // R2
endmodule

bind irbaud_gen irbaud_gen_chk #(.PRESCALE(PRESCALE), .OVS(OVERSAMPLE)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .en          (en),
    .sample_tick (sample_tick),
    .bit_tick    (bit_tick)
);

// File: tb/tb_irbaud_gen.sv
module tb_irbaud_gen;
    localparam int PRE = 26;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        en = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic        sample_tick;
    logic        bit_tick;

    int cyc = 0;
    int n_chk = 0;
    int n_fail = 0;

    irbaud_gen dut (
        .clk         (clk),
        .rst         (rst),
        .en          (en),
        .wr_en       (wr_en),
        .wr_data     (wr_data),
        .sample_tick (sample_tick),
        .bit_tick    (bit_tick)
    );

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_tick(output int stamp);
        @(negedge clk);
        while (!sample_tick) @(negedge clk);
        stamp = cyc;
    endtask

    task automatic wr(logic [15:0] v);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Enable and measure the first sample strobe, the first bit strobe,
    // and how many sample strobes come up to and including it
    task automatic run_from_enable(string req, int n);
        int t0, first, bitat, ns;
        first = -1;
        bitat = -1;
        ns = 0;
        @(negedge clk);
        en = 1'b1;
        t0 = cyc;
        while (bitat < 0) begin
            @(negedge clk);
            if (sample_tick) begin
                ns++;
                if (ns == 1) first = cyc - t0;
            end
            if (bit_tick) bitat = cyc - t0;
        end
        chk({req, " first sample delay"}, first, PRE * (n + 1) - 1);
        chk({req, " first bit delay"}, bitat, 16 * PRE * (n + 1) - 1);
        chk({req, " samples per bit"}, ns, 16);
    endtask

    task automatic t_period(string req, logic [15:0] v, int n);
        int a, b;
        wr(v);
        wait_tick(a);
        wait_tick(a);
        wait_tick(b);
        chk({req, " sample period"}, b - a, PRE * (n + 1));
        @(negedge clk);
        chk("R4 pulse width", int'(sample_tick), 0);
    endtask

    task automatic t_reset();
        int seen;
        seen = 0;
        repeat (5) begin
            @(negedge clk);
            if (sample_tick || bit_tick) seen++;
        end
        chk("R1 strobes in reset", seen, 0);
        rst = 1'b0;
        repeat (40) begin
            @(negedge clk);
            if (sample_tick || bit_tick) seen++;
        end
        chk("R1 strobes while idle", seen, 0);
    endtask

    task automatic t_change_mid();
        int a, b, c;
        wait_tick(a);
        repeat (100) @(negedge clk);
        wr(16'd3);
        wait_tick(b);
        wait_tick(c);
        chk("R6 old period kept", b - a, PRE * 12);
        chk("R6 new period", c - b, PRE * 4);
    endtask

    task automatic t_change_at_term();
        int a, b;
        wait_tick(a);
        wr_en = 1'b1;
        wr_data = 16'd7;
        @(negedge clk);
        wr_en = 1'b0;
        while (!sample_tick) @(negedge clk);
        b = cyc;
        chk("R6 write at terminal", b - a, PRE * 8);
    endtask

    task automatic t_disable();
        int seen;
        seen = 0;
        repeat (5) begin
            int s;
            wait_tick(s);
        end
        @(negedge clk);
        en = 1'b0;
        repeat (100) begin
            @(negedge clk);
            if (sample_tick || bit_tick) seen++;
        end
        chk("R7 silent while disabled", seen, 0);
        run_from_enable("R7", 0);
    endtask

    task automatic t_write_off();
        int a, b;
        @(negedge clk);
        en = 1'b0;
        wr(16'd2);
        run_from_enable("R8", 2);
        wait_tick(a);
        wait_tick(b);
        chk("R8 period after enable", b - a, PRE * 3);
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
        finish_run();
    end

    initial begin
        t_reset();
        run_from_enable("R9", 11);             // R1 reset count, R5 alignment
        t_period("R2 count 11", 16'd11, 11);
        t_period("R2 count 0", 16'd0, 0);
        t_period("R2 count 63", 16'd63, 63);
        t_period("R3 upper bits", 16'hFFC5, 5);
        t_period("R3 bit6 only", 16'h0040, 0);
        t_period("R2 restore 11", 16'd11, 11);
        t_change_mid();
        t_change_at_term();
        wr(16'd0);
        t_disable();
        t_write_off();
        finish_run();
    end
endmodule